// File: doc/BRIEF.md
# Dithered 14-bit PWM DAC

This block produces one pulse-width-modulated bit whose average level, once smoothed by an external integrator, carries a 14-bit value. It has a 14-bit counter that advances on every cycle where the PWM clock enable is high. Every 128 enabled clocks a new period begins. The upper seven bits of the programmed value, called the coarse part, set how many clocks of each period the output is high. The lower seven bits, called the fine part, lengthen chosen periods by one clock. The chosen periods are spread evenly over a 128-period super-cycle, so the mean duty cycle has 14-bit resolution while the ripple frequency stays that of a 7-bit PWM.

A host writes the value through two 8-bit registers: a low register and a high register. An internal operative copy feeds the compare and dither logic. That copy takes the host value only at period boundaries, and it never does so between a low-register write and the high-register write that completes it. A host that needs only six bits of precision may write the high register alone.

Top module: `dither_pwm_dac`

## Requirements
- R1: A synchronous reset clears the counter, both host registers, the operative value, the pending-load flag and the output. After reset the output stays low until a non-zero value has been written and loaded.
- R2: The counter and the output change only on clock edges where `pwmEn` is high. While `pwmEn` is low the output holds its level.
- R3: A period is 128 enabled clocks, with counter bits 6:0 running from 0 to 127. For a value with a non-zero coarse part, the output is high from count 0 onward as one contiguous run, then low until the period ends.
- R4: The coarse part is value bits 13:7. In a period that is not stretched, the output is high for exactly that many enabled clocks, which are counts 0 to coarse-1.
- R5: When the coarse part is zero, the clear wins over the set at the period start, and an unstretched period is low throughout.
- R6: Let p be the period index, which is counter bits 13:7. If p is non-zero and its lowest set bit is at position k, the period is stretched exactly when fine bit (6-k) of the value is 1. A stretched period is high for coarse+1 clocks. Period 0 is never stretched.
- R7: A value written during a period has no effect on that period. It takes effect from the next period start.
- R8: A low-register write without a high-register write marks a load as pending, and no period start loads the operative value while it is pending. A high-register write clears the pending state, and a high-register write alone is enough to make a new value eligible for loading.
- R9: Value bits 7:0 come from the low register. Value bits 13:8 come from bits 5:0 of the high register, and high-register bits 7:6 are ignored.
- R10: Writing the low and high registers in the same cycle counts as a completed load, and that value loads at the next period start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwmEn | input | 1 | PWM clock enable; the counter advances on cycles where it is high |
| loWr | input | 1 | Write strobe for the low register |
| loData | input | 8 | Low register data, value bits 7:0 |
| hiWr | input | 1 | Write strobe for the high register |
| hiData | input | 8 | High register data; bits 5:0 are value bits 13:8 |
| pwmOut | output | 1 | PWM output |

## Verification
Three things can happen on the same enabled edge: the set at the period start, the coarse-match clear, and the one-clock stretch. This happens when the coarse part is zero, and also when the coarse part is 127 and the stretch carries into the wrap. The bench programs coarse 0 with fine bit 6 set, which should give alternating periods of one high clock and no high clocks. It programs coarse 127 with all fine bits set, which should give fully high periods in every period except period 0. Each period is captured as a 128-bit pattern and compared with a contiguous run whose length comes from the period index. A long sweep over all 128 periods checks that the stretch decode selects the right periods.

// File: rtl/dpwm_pkg.sv
`timescale 1ns/1ps
package dpwm_pkg;
  // Width of the programmed value and of the free-running counter.
  parameter int CNT_W = 14;
  // Width of a host register.
  parameter int REG_W = 8;
  // Derived: one PWM period covers 2**HALF_W enabled clocks.
  localparam int HALF_W = CNT_W / 2;
  localparam int HI_W   = CNT_W - REG_W;

  // Strobes from control to datapath, valid in the current cycle.
  typedef struct packed {
    logic tick;    // enabled PWM clock edge
    logic wrap;    // this edge moves counter bits to a new period
    logic loadOp;  // operative value takes the host value on this edge
  } dpwmStrobe_t;
endpackage

// File: rtl/dpwm_ctrl.sv
`timescale 1ns/1ps
module dpwm_ctrl #(
  parameter int CntW  = dpwm_pkg::CNT_W,
  parameter int HalfW = CntW / 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pwmEn,
  input  logic                  loWr,
  input  logic                  hiWr,
  output dpwm_pkg::dpwmStrobe_t strobe,
  output logic [CntW-1:0]       nextCount
);
  logic [CntW-1:0] count;
  logic            loadPending;

  assign nextCount = count + 1'b1;

  // Free-running counter, advanced only by the enable.
  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (pwmEn) count <= nextCount;
  end

  // Pending-load flag: armed by a low write, released by a high write.
  always_ff @(posedge clk) begin
    if (rst)       loadPending <= 1'b0;
    else if (hiWr) loadPending <= 1'b0;
    else if (loWr) loadPending <= 1'b1;
  end

  always_comb begin
    strobe.tick   = pwmEn;
    strobe.wrap   = pwmEn && (nextCount[HalfW-1:0] == '0);
    strobe.loadOp = strobe.wrap && !loadPending;
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pwmEn |=> $stable(count));

  // R8
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    hiWr |=> !loadPending);

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (loWr && !hiWr) |=> loadPending);
endmodule

// File: rtl/dpwm_dither.sv
`timescale 1ns/1ps
module dpwm_dither #(
  parameter int HalfW = dpwm_pkg::HALF_W
) (
  input  logic [HalfW-1:0] fineBits,
  input  logic [HalfW-1:0] periodIdx,
  output logic             stretch
);
  logic [HalfW-1:0] terms;

  // Fine bit j pairs with a period index whose lowest set bit is HalfW-1-j.
  for (genvar j = 0; j < HalfW; j++) begin : g_term
    if (j == HalfW - 1) begin : g_top
      assign terms[j] = fineBits[j] & periodIdx[0];
    end else begin : g_rest
      assign terms[j] = fineBits[j] & periodIdx[HalfW-1-j]
                        & (periodIdx[HalfW-2-j:0] == '0);
    end
  end

  assign stretch = |terms;
endmodule

// File: rtl/dpwm_datapath.sv
`timescale 1ns/1ps
module dpwm_datapath #(
  parameter int CntW  = dpwm_pkg::CNT_W,
  parameter int RegW  = dpwm_pkg::REG_W,
  parameter int HalfW = CntW / 2,
  parameter int HiW   = CntW - RegW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpwm_pkg::dpwmStrobe_t strobe,
  input  logic [CntW-1:0]       nextCount,
  input  logic                  loWr,
  input  logic [RegW-1:0]       loData,
  input  logic                  hiWr,
  input  logic [RegW-1:0]       hiData,
  output logic                  pwmOut
);
  logic [RegW-1:0]  hostLo;
  logic [HiW-1:0]   hostHi;
  logic [CntW-1:0]  opVal;
  logic [CntW-1:0]  effVal;
  logic [HalfW-1:0] coarse;
  logic [HalfW-1:0] fine;
  logic             coarseHit;
  logic             fineHit;
  logic             extHold;
  logic             outQ;
  logic             unusedHiBits;

  assign unusedHiBits = ^hiData[RegW-1:HiW];

  // Host registers, written on any cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      hostLo <= '0;
      hostHi <= '0;
    end else begin
      if (loWr) hostLo <= loData;
      if (hiWr) hostHi <= hiData[HiW-1:0];
    end
  end

  // Operative copy, refreshed at permitted period starts.
  always_ff @(posedge clk) begin
    if (rst)              opVal <= '0;
    else if (strobe.loadOp) opVal <= {hostHi, hostLo};
  end

  // At a loading wrap the new value already governs the new period.
  assign effVal    = strobe.loadOp ? {hostHi, hostLo} : opVal;
  assign coarse    = effVal[CntW-1:HalfW];
  assign fine      = effVal[HalfW-1:0];
  assign coarseHit = strobe.tick && (nextCount[HalfW-1:0] == coarse);

  dpwm_dither #(.HalfW(HalfW)) dither_i (
    .fineBits (fine),
    .periodIdx(nextCount[CntW-1:HalfW]),
    .stretch  (fineHit)
  );

  // Output flip-flop: a plain match clears it, the wrap sets it,
  // and a stretched match clears it one enabled clock later.
  always_ff @(posedge clk) begin
    if (rst) begin
      outQ    <= 1'b0;
      extHold <= 1'b0;
    end else if (strobe.tick) begin
      extHold <= coarseHit && fineHit;
      if (coarseHit && !fineHit) outQ <= 1'b0;
      else if (strobe.wrap)      outQ <= 1'b1;
      else if (extHold)          outQ <= 1'b0;
    end
  end

  assign pwmOut = outQ;

  // R7
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadOp |=> $stable(opVal));

  // R6
  ext_high_chk: assert property (@(posedge clk) disable iff (rst)
    extHold |-> outQ);

  // R2
  out_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(outQ) |-> $past(strobe.tick));

  // R2
  out_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.tick |=> $stable(outQ));
endmodule

// File: rtl/dither_pwm_dac.sv
`timescale 1ns/1ps
module dither_pwm_dac #(
  parameter int CntW = dpwm_pkg::CNT_W,
  parameter int RegW = dpwm_pkg::REG_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwmEn,
  input  logic            loWr,
  input  logic [RegW-1:0] loData,
  input  logic            hiWr,
  input  logic [RegW-1:0] hiData,
  output logic            pwmOut
);
  localparam int HalfW = CntW / 2;
  localparam int HiW   = CntW - RegW;

  dpwm_pkg::dpwmStrobe_t strobe;
  logic [CntW-1:0]       nextCount;

  dpwm_ctrl #(.CntW(CntW), .HalfW(HalfW)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .pwmEn    (pwmEn),
    .loWr     (loWr),
    .hiWr     (hiWr),
    .strobe   (strobe),
    .nextCount(nextCount)
  );

  dpwm_datapath #(.CntW(CntW), .RegW(RegW), .HalfW(HalfW), .HiW(HiW)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .nextCount(nextCount),
    .loWr     (loWr),
    .loData   (loData),
    .hiWr     (hiWr),
    .hiData   (hiData),
    .pwmOut   (pwmOut)
  );
endmodule

// File: tb/dither_pwm_dac_tb.sv
`timescale 1ns/1ps
module dither_pwm_dac_tb_top;
  logic       clk = 1'b0;
  logic       rst, pwmEn, loWr, hiWr;
  logic [7:0] loData, hiData;
  logic       pwmOut;

  int  applied = 0;
  int  bad = 0;
  int  benchCnt = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  dither_pwm_dac dut_i (
    .clk(clk), .rst(rst), .pwmEn(pwmEn), .loWr(loWr), .loData(loData),
    .hiWr(hiWr), .hiData(hiData), .pwmOut(pwmOut)
  );

  typedef struct packed {
    logic [7:0] lo;
    logic [7:0] hi;
    logic [7:0] nPer;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS[NVEC] = '{
    '{lo: 8'h80, hi: 8'h00, nPer: 8'd3},  // coarse 1
    '{lo: 8'h00, hi: 8'h20, nPer: 8'd3},  // coarse 64
    '{lo: 8'hFF, hi: 8'h3F, nPer: 8'd4},  // coarse 127, all fine
    '{lo: 8'h40, hi: 8'h00, nPer: 8'd4},  // coarse 0, fine bit 6
    '{lo: 8'h00, hi: 8'h00, nPer: 8'd2},  // all zero
    '{lo: 8'h00, hi: 8'hC5, nPer: 8'd2},  // upper high bits ignored
    '{lo: 8'h55, hi: 8'h0A, nPer: 8'd4}   // mixed
  };
  localparam string TAGS[NVEC] = '{"R4", "R4", "R6", "R5", "R5", "R9", "R6"};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit en);
    @(negedge clk);
    pwmEn = en; loWr = 1'b0; hiWr = 1'b0;
    @(posedge clk);
    #1;
    if (en) benchCnt = (benchCnt + 1) % 16384;
  endtask

  task automatic writeRegs(input bit wl, input logic [7:0] l,
                           input bit wh, input logic [7:0] h);
    @(negedge clk);
    pwmEn = 1'b0; loWr = wl; loData = l; hiWr = wh; hiData = h;
    @(posedge clk);
    #1;
  endtask

  task automatic toEnd(output int highs);
    highs = 0;
    while (benchCnt % 128 != 127) begin
      step(1'b1);
      highs += int'(pwmOut);
    end
  endtask

  // Expected high clocks for a 14-bit value in period p (R4, R6).
  function automatic int expHigh(input int val, input int p);
    int coarse = (val >> 7) & 127;
    int fine   = val & 127;
    int st     = 0;
    if (p != 0) begin
      int k = 0;
      while (((p >> k) & 1) == 0) k++;
      st = (fine >> (6 - k)) & 1;
    end
    return coarse + st;
  endfunction

  function automatic logic [127:0] maskOf(input int h);
    logic [127:0] m = '0;
    for (int i = 0; i < h; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Runs one full period from count 127; checks a contiguous run (R3).
  task automatic checkPeriod(input int val, input string req);
    logic [127:0] pat;
    int p, e;
    for (int k = 0; k < 128; k++) begin
      step(1'b1);
      pat[k] = pwmOut;
    end
    p = benchCnt / 128;
    e = expHigh(val, p);
    chk(pat == maskOf(e), req, $countones(pat), e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      applied++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin : stim
    int h, val, valB, p;
    bit stable;
    logic lvl;
    rst = 1'b1; pwmEn = 1'b0; loWr = 1'b0; hiWr = 1'b0;
    loData = '0; hiData = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(pwmOut == 1'b0, "R1 reset output", int'(pwmOut), 0);
    @(negedge clk);
    rst = 1'b0;
    benchCnt = 0;

    // R1: nothing written yet, period 0 stays low.
    toEnd(h);
    chk(h == 0, "R1 idle after reset", h, 0);

    // Vector table: both registers written together, checked per period.
    for (int v = 0; v < NVEC; v++) begin
      val = {VECS[v].hi[5:0], VECS[v].lo};
      writeRegs(1'b1, VECS[v].lo, 1'b1, VECS[v].hi);
      for (int n = 0; n < int'(VECS[v].nPer); n++) checkPeriod(val, TAGS[v]);
    end

    // R8: low write alone is held off; the high write completes it.
    val = 14'h0500;
    writeRegs(1'b1, 8'h00, 1'b1, 8'h05);
    checkPeriod(val, "R8 baseline");
    writeRegs(1'b1, 8'hC0, 1'b0, 8'h00);
    checkPeriod(val, "R8 pending hold");
    checkPeriod(val, "R8 pending hold 2");
    writeRegs(1'b0, 8'h00, 1'b1, 8'h09);
    val = 14'h09C0;
    checkPeriod(val, "R8 completed");

    // R8: high write alone keeps the old low byte.
    writeRegs(1'b0, 8'h00, 1'b1, 8'h02);
    val = 14'h02C0;
    checkPeriod(val, "R8 high only");

    // R10: pending low write, then both in one cycle.
    writeRegs(1'b1, 8'h11, 1'b0, 8'h00);
    writeRegs(1'b1, 8'h80, 1'b1, 8'h0C);
    val = 14'h0C80;
    checkPeriod(val, "R10 same cycle");

    // R7: mid-period write does not disturb the current period.
    val = 14'h0A00; valB = 14'h1E00;
    h = 0;
    for (int k = 0; k < 40; k++) begin step(1'b1); h += int'(pwmOut); end
    writeRegs(1'b1, 8'h00, 1'b1, 8'h1E);
    for (int k = 0; k < 88; k++) begin step(1'b1); h += int'(pwmOut); end
    p = benchCnt / 128;
    chk(h == expHigh(14'h0C80, p), "R7 current period", h, expHigh(14'h0C80, p));
    checkPeriod(valB, "R7 next period");

    // R2: enable held low mid-period freezes the output and the count.
    h = 0;
    for (int k = 0; k < 12; k++) begin step(1'b1); h += int'(pwmOut); end
    lvl = pwmOut;
    stable = 1'b1;
    for (int k = 0; k < 30; k++) begin
      step(1'b0);
      if (pwmOut !== lvl) stable = 1'b0;
    end
    chk(stable, "R2 output frozen", int'(stable), 1);
    for (int k = 0; k < 116; k++) begin step(1'b1); h += int'(pwmOut); end
    p = benchCnt / 128;
    chk(h == expHigh(valB, p), "R2 period length", h, expHigh(valB, p));

    // R6 sweep: coarse 3, fine bits 0 and 5, every period of a super-cycle.
    val = (3 << 7) | 7'h21;
    writeRegs(1'b1, val[7:0], 1'b1, 8'(val >> 8));
    for (int n = 0; n < 128; n++) checkPeriod(val, "R6 sweep");

    // R1: reset in mid-run clears registers and output.
    step(1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk(pwmOut == 1'b0, "R1 mid-run reset", int'(pwmOut), 0);
    @(negedge clk);
    rst = 1'b0;
    benchCnt = 0;
    toEnd(h);
    chk(h == 0, "R1 period 0 after reset", h, 0);
    checkPeriod(0, "R1 host cleared");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule